// File: doc/BRIEF.md
# Input Change and Error Interrupt Controller

This block watches a small bank of digital input channels and a group of error flags, and drives one level-sensitive interrupt request line to a host. A four-bit control word sets four things: whether short input pulses are captured for the host, whether input changes may interrupt, which edge direction counts as a change (one setting for every channel), and whether errors may interrupt. A per-channel allow mask limits which inputs can raise an input-change interrupt.

Once raised, the interrupt stays high until the host completes a clear handshake: it raises a command request, and the block answers with a completion acknowledge. The block records which channels caused the interrupt and whether an error is the cause. When errors may interrupt, they take precedence, and new input changes are not recorded.

Top module: `chg_err_irq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `irq`, `cause_err`, `cmd_ack`, `pend_chan` and `rd_data` are all zero.
- R2: Bit 1 of `ctrl` enables input-change interrupts. When it is 0, no bit of `pend_chan` is newly set.
- R3: A channel whose bit in `allow_mask` is 0 never sets its `pend_chan` bit.
- R4: Bit 2 of `ctrl` picks the edge for all channels: 0 records an OFF-to-ON change and 1 records an ON-to-OFF change. The change is recorded in `pend_chan` on the clock edge where the new input value is first sampled, so `pend_chan` shows it after that edge.
- R5: Bit 3 of `ctrl` enables the error interrupt. When it is 1 and any bit of `err_flags` is 1 at a clock edge, `irq` and `cause_err` are 1 after that edge. When it is 0, `err_flags` has no effect.
- R6: When bit 3 of `ctrl` is 1, input changes are not recorded in `pend_chan`, even if bit 1 is also 1.
- R7: A rising edge of `cmd_req` clears `pend_chan` and `cause_err` on that clock. `cmd_ack` follows `cmd_req` one cycle later.
- R8: A qualifying edge or an enabled error that is present on the clearing clock is kept, so `irq` stays high after the clear.
- R9: Bit 0 of `ctrl` enables input hold. When it is 1, any channel seen ON shows as 1 in `rd_data` until the host reads. When it is 0, `rd_data` equals the input as it was one clock earlier.
- R10: A `rd_strobe` at a clock edge releases the held bits on that edge. A channel still ON at that edge stays 1.
- R11: `irq` is 1 exactly when `pend_chan` has any bit set or `cause_err` is 1.
- R12: An enabled error that arrives while input-change bits are pending sets `cause_err` and keeps the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl | input | 4 | Bit 0 hold, bit 1 change enable, bit 2 falling select, bit 3 error enable |
| allow_mask | input | NCH | Per-channel interrupt allow |
| din | input | NCH | Input channels, 1 = ON |
| err_flags | input | NERR | Error flags, 1 = error present |
| rd_strobe | input | 1 | Host reads the input data this cycle |
| rd_data | output | NCH | Input data seen by the host |
| cmd_req | input | 1 | Clear command request |
| cmd_ack | output | 1 | Clear completion acknowledge |
| irq | output | 1 | Interrupt request level |
| cause_err | output | 1 | Pending cause is an error |
| pend_chan | output | NCH | Channels with a recorded change |

## Verification
A wrong edge register or edge select would show as the wrong set of bits in `pend_chan` one clock after an input step. The bench sweeps every pair of before and after input values against every mask and both edge settings. A wrong clear or priority term shows up on the cycle after `cmd_req` rises or an error arrives, through `irq`, `cause_err` and `pend_chan`. A faulty hold register shows as a wrong `rd_data` one clock after a pulse or a read.

// File: rtl/chgirq_pkg.sv
package chgirq_pkg;
    localparam int CTL_W      = 4;
    localparam int CTL_HOLD   = 0;
    localparam int CTL_CHG_EN = 1;
    localparam int CTL_FALL   = 2;
    localparam int CTL_ERR_EN = 3;
endpackage

// File: rtl/chgirq_edge.sv
module chgirq_edge #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] din,
    input  logic           fall_sel,
    output logic [NCH-1:0] din_q,
    output logic [NCH-1:0] edge_hit
);
    logic [NCH-1:0] din_d;
    logic [NCH-1:0] smp_q;

    always_comb begin
        din_d = din;
        for (int i = 0; i < NCH; i++) begin
            edge_hit[i] = fall_sel ? (smp_q[i] & ~din[i]) : (din[i] & ~smp_q[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= din_d;
    end

    assign din_q = smp_q;
endmodule

// File: rtl/chgirq_hold.sv
module chgirq_hold #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold_en,
    input  logic           rd_strobe,
    input  logic [NCH-1:0] din,
    output logic [NCH-1:0] held
);
    logic [NCH-1:0] held_d;
    logic [NCH-1:0] held_q;

    always_comb begin
        if (!hold_en)       held_d = '0;
        else if (rd_strobe) held_d = din;
        else                held_d = held_q | din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= '0;
        else        held_q <= held_d;
    end

    assign held = held_q;
endmodule

// File: rtl/chg_err_irq.sv
module chg_err_irq
    import chgirq_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int NERR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CTL_W-1:0] ctrl,
    input  logic [NCH-1:0]   allow_mask,
    input  logic [NCH-1:0]   din,
    input  logic [NERR-1:0]  err_flags,
    input  logic             rd_strobe,
    output logic [NCH-1:0]   rd_data,
    input  logic             cmd_req,
    output logic             cmd_ack,
    output logic             irq,
    output logic             cause_err,
    output logic [NCH-1:0]   pend_chan
);
    typedef struct packed {
        logic [NCH-1:0] pend;
        logic           err;
        logic           ack;
        logic           irq;
    } st_t;

    st_t st_d, st_q;

    logic [NCH-1:0] din_q;
    logic [NCH-1:0] edge_hit;
    logic [NCH-1:0] held;
    logic [NCH-1:0] qual;
    logic           chg_live;
    logic           err_live;
    logic           clr;

    chgirq_edge #(.NCH(NCH)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .fall_sel (ctrl[CTL_FALL]),
        .din_q    (din_q),
        .edge_hit (edge_hit)
    );

    chgirq_hold #(.NCH(NCH)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_en   (ctrl[CTL_HOLD]),
        .rd_strobe (rd_strobe),
        .din       (din),
        .held      (held)
    );

    always_comb begin
        // error enable overrides change enable
        chg_live = ctrl[CTL_CHG_EN] & ~ctrl[CTL_ERR_EN];
        err_live = ctrl[CTL_ERR_EN] & (|err_flags);
        qual     = edge_hit & allow_mask & {NCH{chg_live}};
        clr      = cmd_req & ~st_q.ack;

        st_d      = st_q;
        st_d.ack  = cmd_req;
        st_d.pend = (clr ? '0 : st_q.pend) | qual;
        st_d.err  = (clr ? 1'b0 : st_q.err) | err_live;
        st_d.irq  = (|st_d.pend) | st_d.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data   = ctrl[CTL_HOLD] ? held : din_q;
    assign cmd_ack   = st_q.ack;
    assign irq       = st_q.irq;
    assign cause_err = st_q.err;
    assign pend_chan = st_q.pend;
endmodule

// File: rtl/chg_err_irq_chk.sv
module chg_err_irq_chk
    import chgirq_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int NERR = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CTL_W-1:0] ctrl,
    input logic [NCH-1:0]   allow_mask,
    input logic [NCH-1:0]   din,
    input logic [NERR-1:0]  err_flags,
    input logic [NCH-1:0]   rd_data,
    input logic             cmd_req,
    input logic             cmd_ack,
    input logic             irq,
    input logic             cause_err,
    input logic [NCH-1:0]   pend_chan
);
    assert_irq_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((|pend_chan) || cause_err));

    assert_no_new_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ((pend_chan & ~$past(pend_chan)) != '0)
        |-> ($past(ctrl[CTL_CHG_EN]) && !$past(ctrl[CTL_ERR_EN])));

    assert_mask_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend_chan & ~$past(pend_chan) & ~$past(allow_mask)) == '0));

    assert_err_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CTL_ERR_EN] && (|err_flags)) |=> (irq && cause_err));

    assert_ack_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_req) |=> cmd_ack);

    assert_clear_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(cmd_req) && (din == $past(din)) && !(|err_flags))
        |=> !irq);

    assert_no_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ctrl[CTL_HOLD]) |-> (rd_data == $past(din)));
endmodule

bind chg_err_irq chg_err_irq_chk #(.NCH(NCH), .NERR(NERR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .allow_mask (allow_mask),
    .din        (din),
    .err_flags  (err_flags),
    .rd_data    (rd_data),
    .cmd_req    (cmd_req),
    .cmd_ack    (cmd_ack),
    .irq        (irq),
    .cause_err  (cause_err),
    .pend_chan  (pend_chan)
);

// File: tb/chg_err_irq_tb.sv
module chg_err_irq_tb;
    localparam int NCH  = 4;
    localparam int NERR = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [3:0]      ctrl = '0;
    logic [NCH-1:0]  allow_mask = '0;
    logic [NCH-1:0]  din = '0;
    logic [NERR-1:0] err_flags = '0;
    logic            rd_strobe = 1'b0;
    logic [NCH-1:0]  rd_data;
    logic            cmd_req = 1'b0;
    logic            cmd_ack;
    logic            irq;
    logic            cause_err;
    logic [NCH-1:0]  pend_chan;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    chg_err_irq #(.NCH(NCH), .NERR(NERR)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .allow_mask(allow_mask),
        .din(din), .err_flags(err_flags), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .cmd_req(cmd_req), .cmd_ack(cmd_ack),
        .irq(irq), .cause_err(cause_err), .pend_chan(pend_chan)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_clear();
        cmd_req = 1'b1; step();
        cmd_req = 1'b0; step();
    endtask

    initial begin
        step(); step();
        chk("R1 irq", irq, 0);
        chk("R1 pend", pend_chan, 0);
        chk("R1 ack", cmd_ack, 0);
        rst_n = 1'b1; step();
        chk("R1 first cycle irq/cause", {irq, cause_err, cmd_ack}, 0);
        chk("R1 rd_data", rd_data, 0);

        // R2 R3 R4: sweep edge select, enable, mask, before and after values
        for (int fs = 0; fs < 2; fs++) begin
            for (int en = 0; en < 2; en++) begin
                for (int m = 0; m < 16; m++) begin
                    for (int p = 0; p < 16; p++) begin
                        for (int q = 0; q < 16; q++) begin
                            logic [3:0] e;
                            ctrl = {1'b0, fs[0], en[0], 1'b0};
                            allow_mask = m[3:0];
                            din = p[3:0]; step();
                            do_clear();
                            din = q[3:0]; step();
                            e = fs ? (p[3:0] & ~q[3:0]) : (q[3:0] & ~p[3:0]);
                            e = en ? (e & m[3:0]) : 4'h0;
                            chk("R4 R3 R2 pend_chan", pend_chan, e);
                            chk("R11 irq", irq, (e != 0));
                        end
                    end
                end
            end
        end
        din = '0; ctrl = '0; do_clear();

        // R7 handshake
        ctrl = 4'b0010; allow_mask = 4'hF; din = 4'b0100; step();
        chk("R7 pend before clear", pend_chan, 4'b0100);
        cmd_req = 1'b1; step();
        chk("R7 cleared", {irq, pend_chan}, 0);
        chk("R7 ack high", cmd_ack, 1);
        step();
        chk("R7 no clear on held req", cmd_ack, 1);
        cmd_req = 1'b0; step();
        chk("R7 ack low", cmd_ack, 0);

        // R8 new edge in the clearing cycle is kept
        din = 4'b0101; step();
        cmd_req = 1'b1; din = 4'b0111; step();
        chk("R8 edge kept over clear", pend_chan, 4'b0010);
        chk("R8 irq stays", irq, 1);
        cmd_req = 1'b0; step(); do_clear();
        din = '0; step(); do_clear();

        // R5 error interrupt
        ctrl = 4'b0000; err_flags = 2'b10; step();
        chk("R5 error ignored when disabled", {irq, cause_err}, 0);
        ctrl = 4'b1000; step();
        chk("R5 error raises", {irq, cause_err}, 2'b11);
        // R8 persistent error reasserts through clear
        cmd_req = 1'b1; step();
        chk("R8 error persists", {irq, cause_err}, 2'b11);
        cmd_req = 1'b0; err_flags = '0; step();
        chk("R5 latched until clear", irq, 1);
        do_clear();
        chk("R7 error cleared", {irq, cause_err}, 0);

        // R6 priority
        ctrl = 4'b1010; din = 4'b1111; step();
        chk("R6 change suppressed", pend_chan, 0);
        din = '0; ctrl = 4'b0010; step(); do_clear();

        // R12 cause switch
        din = 4'b0001; step();
        chk("R12 change pending", {cause_err, pend_chan}, 5'b00001);
        ctrl = 4'b1010; err_flags = 2'b01; step();
        chk("R12 cause now error", {cause_err, pend_chan}, 5'b10001);
        err_flags = '0; do_clear();
        chk("R12 all cleared", {irq, cause_err, pend_chan}, 0);
        din = '0; ctrl = '0; step();

        // R9 R10 hold
        ctrl = 4'b0000; din = 4'b1010; step();
        chk("R9 no hold follows", rd_data, 4'b1010);
        din = 4'b0000; step();
        chk("R9 no hold drops", rd_data, 0);
        ctrl = 4'b0001; din = 4'b0101; step();
        din = 4'b0000; step(); step();
        chk("R9 pulse held", rd_data, 4'b0101);
        din = 4'b0001; rd_strobe = 1'b1; step();
        rd_strobe = 1'b0;
        chk("R10 release keeps live bit", rd_data, 4'b0001);
        din = 4'b0000; rd_strobe = 1'b1; step();
        rd_strobe = 1'b0;
        chk("R10 released", rd_data, 0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 190000; c++) begin
            if (done) break;
            @(posedge clk);
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule